// File: doc/BRIEF.md
# Two-Phase SPI Register Access Master

This block is an SPI master for a peripheral that splits every register access into two chip-select frames. In the first frame it shifts out an 8-bit command byte while a separate command-select output is high. At the same time it captures the byte the peripheral returns on MISO as a status byte. In the second frame the command-select output is low and the block moves either the single most significant byte of the register or the whole 32-bit word, as the host selects.

If the status byte carries the communication-error code (0x04), the block skips the data frame. It then finishes the request with the error flag set. The host presents a request with a command byte, a direction flag, a size select and write data while `busy_o` is low. It collects the results when `done_o` pulses.

Top module: `two_phase_spi_master`

## Requirements
- R1: In the command frame, `cmd_sel_o` is high before `cs_no` falls and stays high until after `cs_no` rises; exactly 8 bits are clocked, carrying `cmd_i` most significant bit first.
- R2: The 8 bits sampled on MISO during the command frame appear on `status_o`, first received bit in bit 7.
- R3: If that status byte equals 0x04, `com_err_o` is high at `done_o` and no data frame occurs; otherwise `com_err_o` is low at `done_o`.
- R4: The data frame runs with `cmd_sel_o` low and clocks 32 bits when `wide_i`=1 or 8 bits when `wide_i`=0.
- R5: On a read (`wr_i`=0), `rdata_o` holds the received word with the first byte received in bits 31:24. In 8-bit mode that byte sits in bits 31:24 and bits 23:0 are zero. A write leaves `rdata_o` unchanged.
- R6: On a write, MOSI carries `wdata_i` most significant bit first in 32-bit mode, or `wdata_i[31:24]` in 8-bit mode. On a read, MOSI carries all zeros.
- R7: SPI mode 0. SCLK is low whenever `cs_no` is high. Each SCLK half period lasts `CLK_DIV` system clocks, and MISO is sampled on the rising edge.
- R8: Between the two frames `cs_no` stays high for at least `CS_GAP` system clocks, and `cmd_sel_o` changes only while `cs_no` is high.
- R9: A request is taken only while `busy_o` is low, and `busy_o` rises the cycle after acceptance. `req_i` while busy has no effect. `done_o` is a one-cycle pulse during which `busy_o` is already low.
- R10: After reset, `cs_no` is high, and `sclk_o`, `cmd_sel_o`, `busy_o`, `done_o` and `com_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| cmd_i | input | 8 | Command byte |
| wr_i | input | 1 | 1 = write, 0 = read |
| wide_i | input | 1 | 1 = 32-bit data frame, 0 = 8-bit data frame |
| wdata_i | input | 32 | Write data |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read data |
| status_o | output | 8 | Status byte captured in the command frame |
| com_err_o | output | 1 | Status byte matched the error code |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data out |
| miso_i | input | 1 | SPI data in |
| cs_no | output | 1 | Chip select, active low |
| cmd_sel_o | output | 1 | Command-select line, high during the command frame |

## Verification
The bench builds the block with `CLK_DIV`=3 and `CS_GAP`=4. With these values a full 32-bit access takes about 250 system clocks, so hundreds of random accesses fit in the run. They cover every mix of direction, size and error status. The short divider also makes the exact SCLK half-period measurable. The gap of four cycles is larger than the single fixed cycle the sequencer always inserts, so a gap counter that stops early shows up in the measured chip-select high time.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_CMD,
    ST_POST,
    ST_GAP,
    ST_DATA,
    ST_FIN
  } tps_state_e;
endpackage

// File: rtl/tps_shift.sv
// Mode 0 bit engine: shifts MSB first, samples on SCLK rise.
module tps_shift #(
  parameter int unsigned CLK_DIV = 5,
  parameter int unsigned MAXB    = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [5:0]      nbits_i,
  input  logic [MAXB-1:0] tx_i,
  input  logic            miso_i,
  output logic            sclk_o,
  output logic            mosi_o,
  output logic [MAXB-1:0] rx_o,
  output logic            done_o
);
  localparam int unsigned DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int unsigned BW = $clog2(MAXB);

  logic            act_q, sclk_q, done_q;
  logic [DW-1:0]   cnt_q;
  logic [BW-1:0]   left_q;
  logic [MAXB-1:0] sreg_q, rx_q;
  logic            half_end;

  assign half_end = (cnt_q == DW'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      left_q <= '0;
      sreg_q <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        act_q  <= 1'b1;
        sclk_q <= 1'b0;
        cnt_q  <= '0;
        left_q <= BW'(nbits_i - 6'd1);
        sreg_q <= tx_i;
        rx_q   <= '0;
      end else if (act_q) begin
        if (half_end) begin
          cnt_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[MAXB-2:0], miso_i};
          end else begin
            sclk_q <= 1'b0;
            if (left_q == '0) begin
              act_q  <= 1'b0;
              done_q <= 1'b1;
            end else begin
              left_q <= left_q - 1'b1;
              sreg_q <= {sreg_q[MAXB-2:0], 1'b0};
            end
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = sreg_q[MAXB-1];
  assign rx_o   = rx_q;
  assign done_o = done_q;

  p_sclk_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |-> !sclk_q);
  p_sclk_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !half_end && !start_i) |=> $stable(sclk_q));
  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !act_q);
endmodule

// File: rtl/tps_ctrl.sv
// Frame sequencer: command frame, gap, optional data frame.
module tps_ctrl
  import tps_pkg::*;
#(
  parameter int unsigned CS_GAP   = 4,
  parameter logic [7:0]  ERR_CODE = 8'h04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic              wr_i,
  input  logic              wide_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              sh_done_i,
  input  logic [WORD_W-1:0] sh_rx_i,
  output logic              sh_start_o,
  output logic [5:0]        sh_nbits_o,
  output logic [WORD_W-1:0] sh_tx_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic [BYTE_W-1:0] status_o,
  output logic              com_err_o,
  output logic              cs_no,
  output logic              cmd_sel_o
);
  localparam int unsigned GW = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;

  tps_state_e        state_q;
  logic [BYTE_W-1:0] cmd_q, status_q;
  logic              wr_q, wide_q, err_q, done_q, cs_q, sel_q;
  logic [WORD_W-1:0] wdata_q, rdata_q, wr_word;
  logic [GW-1:0]     gap_q;
  logic              gap_end, in_pre;

  assign gap_end = (state_q == ST_GAP) && (gap_q == GW'(CS_GAP - 1));
  assign in_pre  = (state_q == ST_PRE);
  assign wr_word = wide_q ? wdata_q : {wdata_q[WORD_W-1 -: BYTE_W], {(WORD_W-BYTE_W){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cmd_q    <= '0;
      status_q <= '0;
      wr_q     <= 1'b0;
      wide_q   <= 1'b0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      cs_q     <= 1'b1;
      sel_q    <= 1'b0;
      gap_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          cmd_q   <= cmd_i;
          wr_q    <= wr_i;
          wide_q  <= wide_i;
          wdata_q <= wdata_i;
          err_q   <= 1'b0;
          sel_q   <= 1'b1;
          state_q <= ST_PRE;
        end
        ST_PRE: begin
          cs_q    <= 1'b0;
          state_q <= ST_CMD;
        end
        ST_CMD: if (sh_done_i) begin
          cs_q     <= 1'b1;
          status_q <= sh_rx_i[BYTE_W-1:0];
          state_q  <= ST_POST;
        end
        ST_POST: begin
          if (status_q == ERR_CODE) begin
            err_q   <= 1'b1;
            state_q <= ST_FIN;
          end else begin
            sel_q   <= 1'b0;
            gap_q   <= '0;
            state_q <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_end) begin
            cs_q    <= 1'b0;
            state_q <= ST_DATA;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        ST_DATA: if (sh_done_i) begin
          cs_q <= 1'b1;
          if (!wr_q)
            rdata_q <= wide_q ? sh_rx_i
                              : {sh_rx_i[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b0}}};
          state_q <= ST_FIN;
        end
        ST_FIN: begin
          sel_q   <= 1'b0;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sh_start_o = in_pre || gap_end;
  assign sh_nbits_o = (in_pre || !wide_q) ? 6'd8 : 6'd32;
  assign sh_tx_o    = in_pre ? {cmd_q, {(WORD_W-BYTE_W){1'b0}}}
                             : (wr_q ? wr_word : '0);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign rdata_o    = rdata_q;
  assign status_o   = status_q;
  assign com_err_o  = err_q;
  assign cs_no      = cs_q;
  assign cmd_sel_o  = sel_q;

  p_sel_cs_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_q) |-> (cs_q && $past(cs_q)));
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_o);
  p_err_skip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POST && status_q == ERR_CODE) |=> (state_q == ST_FIN && err_q));
  p_no_data_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (state_q != ST_DATA && state_q != ST_GAP));
  p_sel_frame_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMD) |-> sel_q);
endmodule

// File: rtl/two_phase_spi_master.sv
module two_phase_spi_master #(
  parameter int unsigned CLK_DIV  = 5,
  parameter int unsigned CS_GAP   = 4,
  parameter logic [7:0]  ERR_CODE = 8'h04
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic [7:0]  cmd_i,
  input  logic        wr_i,
  input  logic        wide_i,
  input  logic [31:0] wdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [31:0] rdata_o,
  output logic [7:0]  status_o,
  output logic        com_err_o,
  output logic        sclk_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        cs_no,
  output logic        cmd_sel_o
);
  logic        sh_start, sh_done;
  logic [5:0]  sh_nbits;
  logic [31:0] sh_tx, sh_rx;

  tps_ctrl #(.CS_GAP(CS_GAP), .ERR_CODE(ERR_CODE)) i_ctrl (
    .clk_i, .rst_ni, .req_i, .cmd_i, .wr_i, .wide_i, .wdata_i,
    .sh_done_i(sh_done), .sh_rx_i(sh_rx),
    .sh_start_o(sh_start), .sh_nbits_o(sh_nbits), .sh_tx_o(sh_tx),
    .busy_o, .done_o, .rdata_o, .status_o, .com_err_o, .cs_no, .cmd_sel_o
  );

  tps_shift #(.CLK_DIV(CLK_DIV), .MAXB(32)) i_shift (
    .clk_i, .rst_ni,
    .start_i(sh_start), .nbits_i(sh_nbits), .tx_i(sh_tx), .miso_i,
    .sclk_o, .mosi_o, .rx_o(sh_rx), .done_o(sh_done)
  );

  p_sclk_low_cs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  p_busy_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o);
endmodule

// File: tb/test_two_phase_spi_master.sv
module test_two_phase_spi_master;
  localparam int unsigned DIV = 3;
  localparam int unsigned GAP = 4;
  localparam int unsigned TCK = 20;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, wr = 1'b0, wide = 1'b0, miso = 1'b0;
  logic [7:0]  cmd = '0;
  logic [31:0] wdata = '0;
  logic busy, done, com_err, sclk, mosi, cs_n, cmd_sel;
  logic [31:0] rdata;
  logic [7:0]  status;

  always #(TCK/2) clk = ~clk;

  two_phase_spi_master #(.CLK_DIV(DIV), .CS_GAP(GAP)) i_two_phase_spi_master (
    .clk_i(clk), .rst_ni, .req_i(req), .cmd_i(cmd), .wr_i(wr), .wide_i(wide),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .status_o(status), .com_err_o(com_err), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n), .cmd_sel_o(cmd_sel)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  // slave model
  int          ph = 0;
  int          bitpos = 0;
  logic [31:0] resp [3];
  logic [31:0] mcap [3];
  int          nbits [3];
  logic        sel_fall [3], sel_rise [3];
  time         t_rise = 0, gap_ns = 0, last_sr = 0;
  bit          have_sr = 1'b0;
  int          sel_viol = 0, sclk_viol = 0, per_viol = 0;

  always @(negedge cs_n) if (rst_ni === 1'b1 && ph < 3) begin
    bitpos = 0;
    have_sr = 1'b0;
    sel_fall[ph] = cmd_sel;
    if (ph == 1) gap_ns = $time - t_rise;
    miso = resp[ph][31];
  end
  always @(posedge sclk) begin
    if (cs_n !== 1'b0) sclk_viol++;
    else if (ph < 3) begin
      mcap[ph] = {mcap[ph][30:0], mosi};
      nbits[ph]++;
      if (have_sr && ($time - last_sr) != 2*DIV*TCK) per_viol++;
      last_sr = $time;
      have_sr = 1'b1;
    end
  end
  always @(negedge sclk) if (cs_n === 1'b0 && ph < 3) begin
    bitpos++;
    if (bitpos < 32) miso = resp[ph][31-bitpos];
  end
  always @(posedge cs_n) if (rst_ni === 1'b1 && ph < 3) begin
    sel_rise[ph] = cmd_sel;
    t_rise = $time;
    ph++;
  end
  always @(cmd_sel) if (rst_ni === 1'b1 && cs_n !== 1'b1) sel_viol++;

  logic [31:0] prev_rdata = '0;

  task automatic txn(input logic [7:0] c, input bit w, input bit wd, input logic [31:0] wv,
                     input logic [7:0] st, input logic [31:0] word, input bit poke);
    bit exp_err;
    logic [31:0] exp_rd, exp_mo;
    int n;
    ph = 0;
    for (int i = 0; i < 3; i++) begin
      mcap[i] = '0; nbits[i] = 0; sel_fall[i] = 1'bx; sel_rise[i] = 1'bx;
    end
    resp[0] = {st, 24'h0};
    resp[1] = word;
    resp[2] = '0;
    sel_viol = 0; sclk_viol = 0; per_viol = 0;
    @(negedge clk);
    req = 1'b1; cmd = c; wr = w; wide = wd; wdata = wv;
    @(negedge clk);
    req = 1'b0;
    chk(busy === 1'b1, "R9 busy after accept", {31'b0, busy}, 32'h1);
    if (poke) begin
      repeat (7) @(negedge clk);
      req = 1'b1; cmd = ~c; wr = ~w; wide = ~wd; wdata = ~wv;
      @(negedge clk);
      req = 1'b0;
    end
    n = 0;
    while (done !== 1'b1 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    exp_err = (st == 8'h04);
    chk(done === 1'b1, "R9 done seen", {31'b0, done}, 32'h1);
    chk(busy === 1'b0, "R9 busy low at done", {31'b0, busy}, 32'h0);
    chk(status === st, "R2 status byte", {24'b0, status}, {24'b0, st});
    chk(com_err === exp_err, "R3 error flag", {31'b0, com_err}, {31'b0, exp_err});
    chk(ph == (exp_err ? 1 : 2), "R3 frame count", ph, exp_err ? 1 : 2);
    chk(nbits[0] == 8 && mcap[0][7:0] == c, "R1 command bits", {nbits[0][7:0], 16'b0, mcap[0][7:0]}, {8'd8, 16'b0, c});
    chk(sel_fall[0] === 1'b1 && sel_rise[0] === 1'b1, "R1 cmd_sel high in command frame",
        {30'b0, sel_fall[0], sel_rise[0]}, 32'h3);
    chk(sel_viol == 0, "R8 cmd_sel change with cs low", sel_viol, 0);
    chk(sclk_viol == 0 && per_viol == 0, "R7 sclk idle and period", sclk_viol * 256 + per_viol, 0);
    if (!exp_err) begin
      chk(nbits[1] == (wd ? 32 : 8), "R4 data bit count", nbits[1], wd ? 32 : 8);
      chk(sel_fall[1] === 1'b0 && sel_rise[1] === 1'b0, "R4 cmd_sel low in data frame",
          {30'b0, sel_fall[1], sel_rise[1]}, 32'h0);
      chk(gap_ns >= GAP*TCK, "R8 chip select gap", gap_ns, GAP*TCK);
      exp_mo = !w ? 32'h0 : (wd ? wv : {24'h0, wv[31:24]});
      chk(mcap[1] == exp_mo, "R6 mosi data", mcap[1], exp_mo);
      exp_rd = w ? prev_rdata : (wd ? word : {word[31:24], 24'h0});
      chk(rdata === exp_rd, "R5 read data", rdata, exp_rd);
    end else begin
      chk(rdata === prev_rdata, "R3 rdata kept on error", rdata, prev_rdata);
      exp_rd = prev_rdata;
    end
    prev_rdata = exp_rd;
    @(negedge clk);
    chk(done === 1'b0, "R9 done single cycle", {31'b0, done}, 32'h0);
    repeat (4) @(negedge clk);
    chk(ph == (exp_err ? 1 : 2) && busy === 1'b0, "R9 no extra request", ph, exp_err ? 1 : 2);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0 && cmd_sel === 1'b0, "R10 reset lines",
        {29'b0, cs_n, sclk, cmd_sel}, 32'h4);
    chk(busy === 1'b0 && done === 1'b0 && com_err === 1'b0, "R10 reset handshake",
        {29'b0, busy, done, com_err}, 32'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    // directed corners
    txn(8'hA5, 1'b0, 1'b1, 32'h0, 8'h00, 32'hDEADBEEF, 1'b0);
    txn(8'h3C, 1'b1, 1'b1, 32'h12345678, 8'h80, 32'hFFFFFFFF, 1'b0);
    txn(8'hFF, 1'b0, 1'b0, 32'h0, 8'h05, 32'hC3000000, 1'b0);
    txn(8'h01, 1'b1, 1'b0, 32'h9A000000, 8'h04, 32'h0, 1'b0);
    txn(8'h81, 1'b0, 1'b1, 32'h0, 8'h04, 32'h55AA55AA, 1'b0);
    txn(8'h42, 1'b1, 1'b1, 32'hCAFEF00D, 8'h06, 32'h11111111, 1'b1);
    txn(8'h7E, 1'b0, 1'b1, 32'h0, 8'h04, 32'h0, 1'b1);
    // random mix
    for (int k = 0; k < 200; k++) begin
      logic [7:0] st;
      st = ($urandom_range(0, 4) == 0) ? 8'h04 : 8'($urandom);
      txn(8'($urandom), 1'($urandom), 1'($urandom), $urandom, st, $urandom,
          ($urandom_range(0, 9) == 0));
    end
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule